// File: doc/BRIEF.md
# Single-Operand Extend, Swap and Set-on-Condition Unit

This unit executes the single-source, register-to-register operations of a small RISC integer pipeline. Each operation is chosen by a 4-bit opcode nibble. It widens a narrow field of the source to the full data width, either with zeros or with copies of the field's top bit. It can reverse the byte order of the whole word. It can also turn a test on the source value into a 0 or 1 result. The data width is a parameter and may be 32 or 64 bits.

The issue stage gives the unit the opcode, the index of the source register and the value read for that register, along with a valid strobe. Index 15 is special in this operation group: whatever value arrives with it, the operand is taken as zero. The unit registers its result, an illegal-opcode flag and a valid strobe. These appear one clock after the request. The writeback stage takes them from there. Register file access and writeback are handled outside the unit.

Top module: `unop_unit`

## Requirements
- R1: After a synchronous active-high reset, `out_valid`, `out_illegal` and `out_result` are all 0.
- R2: `out_valid` is 1 in the cycle after a cycle with `in_valid` = 1, and 0 in the cycle after a cycle with `in_valid` = 0.
- R3: Opcodes 1, 2 and 3 return the low 8, 16 and 32 bits of the operand with all higher bits cleared.
- R4: Opcodes 5, 6 and 7 return the low 8, 16 and 32 bits of the operand, with all higher bits copied from bit 7, 15 and 31 respectively.
- R5: Opcode 4 reverses the order of all bytes across the configured data width, so byte k of the result is byte (DATA_W/8 - 1 - k) of the operand.
- R6: Opcodes 8 to 13 (0x8 to 0xD) return 1 when the operand is, in turn, zero, non-zero, negative, non-negative, greater than zero (as a signed value), or not greater than zero. Otherwise they return 0. All result bits above bit 0 are 0.
- R7: When `in_src_idx` is 15, the operand is zero whatever the value of `in_src_val`.
- R8: Opcodes 0, 14 and 15 set `out_illegal` to 1 with `out_result` 0. Every other opcode sets `out_illegal` to 0.
- R9: A cycle with `in_valid` = 0 leaves `out_result` and `out_illegal` unchanged.
- R10: With DATA_W = 32, opcodes 3 and 7 return the operand unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| in_op | input | 4 | Operation nibble |
| in_src_idx | input | REG_W (4) | Source register index; 15 reads as zero |
| in_src_val | input | DATA_W | Value read for the source register |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_result | output | DATA_W | Registered result |
| out_illegal | output | 1 | Registered flag for an unmapped opcode |

## Verification
The assertions run on every clock. They check the one-cycle valid timing, that the outputs hold when no request arrives, and that an illegal result is zero. They also check the shape of the results: set-on-condition results keep their upper bits at zero, byte zero-extension clears its upper bits, and byte sign-extension fills its upper bits with copies of bit 7. They check that a zero test on index 15 returns 1. The exact values can only be shown by the bench's sweeps, which cover every opcode against boundary and pseudo-random operands at both widths: the full byte reversal, the 16- and 32-bit extensions, the signed "greater than zero" split at the sign boundary, and the pass-through of 4-byte extension at 32 bits.

// File: rtl/unop_pkg.sv
package unop_pkg;

  typedef enum logic [3:0] {
    OPC_NONE = 4'h0,
    OPC_ZX8  = 4'h1,
    OPC_ZX16 = 4'h2,
    OPC_ZX32 = 4'h3,
    OPC_SWAP = 4'h4,
    OPC_SX8  = 4'h5,
    OPC_SX16 = 4'h6,
    OPC_SX32 = 4'h7,
    OPC_SEQZ = 4'h8,
    OPC_SNEZ = 4'h9,
    OPC_SNEG = 4'hA,
    OPC_SNNG = 4'hB,
    OPC_SPOS = 4'hC,
    OPC_SNPS = 4'hD,
    OPC_RSVE = 4'hE,
    OPC_RSVF = 4'hF
  } unop_opc_e;

  typedef enum logic [2:0] {
    KIND_BAD,
    KIND_ZEXT,
    KIND_SEXT,
    KIND_SWAP,
    KIND_COND
  } unop_kind_e;

  // index of the narrow field width: 0 -> 8 bits, 1 -> 16 bits, 2 -> 32 bits
  localparam int FIELD_SEL_W = 2;
  localparam int N_FIELDS    = 3;

endpackage

// File: rtl/unop_decode.sv
module unop_decode
  import unop_pkg::*;
(
  input  logic [3:0]             op,
  output unop_kind_e             kind,
  output logic [FIELD_SEL_W-1:0] field_sel,
  output logic [2:0]             cond_code
);

  always_comb begin
    kind = KIND_BAD;
    unique case (unop_opc_e'(op))
      OPC_ZX8, OPC_ZX16, OPC_ZX32:                       kind = KIND_ZEXT;
      OPC_SX8, OPC_SX16, OPC_SX32:                       kind = KIND_SEXT;
      OPC_SWAP:                                          kind = KIND_SWAP;
      OPC_SEQZ, OPC_SNEZ, OPC_SNEG,
      OPC_SNNG, OPC_SPOS, OPC_SNPS:                      kind = KIND_COND;
      default:                                           kind = KIND_BAD;
    endcase
  end

  // both extension groups put the field size in the two low opcode bits (1..3)
  assign field_sel = op[1:0] - 2'd1;
  // condition group: bits 2:1 choose the test, bit 0 inverts it
  assign cond_code = op[2:0];

endmodule

// File: rtl/unop_extend.sv
module unop_extend
  import unop_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0]      operand,
  input  logic [FIELD_SEL_W-1:0] field_sel,
  output logic [DATA_W-1:0]      zext_val,
  output logic [DATA_W-1:0]      sext_val,
  output logic [DATA_W-1:0]      swap_val
);

  localparam int N_BYTES = DATA_W / 8;

  logic [N_FIELDS-1:0][DATA_W-1:0] zx_opt;
  logic [N_FIELDS-1:0][DATA_W-1:0] sx_opt;

  for (genvar k = 0; k < N_FIELDS; k++) begin : g_field
    localparam int FW = 8 << k;
    if (FW < DATA_W) begin : g_narrow
      assign zx_opt[k] = {{(DATA_W-FW){1'b0}}, operand[FW-1:0]};
      assign sx_opt[k] = {{(DATA_W-FW){operand[FW-1]}}, operand[FW-1:0]};
    end else begin : g_full
      assign zx_opt[k] = operand;
      assign sx_opt[k] = operand;
    end
  end

  for (genvar b = 0; b < N_BYTES; b++) begin : g_swap
    assign swap_val[8*b +: 8] = operand[8*(N_BYTES-1-b) +: 8];
  end

  always_comb begin
    zext_val = '0;
    sext_val = '0;
    case (field_sel)
      2'd0: begin zext_val = zx_opt[0]; sext_val = sx_opt[0]; end
      2'd1: begin zext_val = zx_opt[1]; sext_val = sx_opt[1]; end
      2'd2: begin zext_val = zx_opt[2]; sext_val = sx_opt[2]; end
      default: begin zext_val = '0; sext_val = '0; end
    endcase
  end

endmodule

// File: rtl/unop_cond.sv
module unop_cond #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] operand,
  input  logic [2:0]        cond_code,
  output logic              hit
);

  logic is_zero, is_neg, is_pos, base;

  assign is_zero = (operand == '0);
  assign is_neg  = operand[DATA_W-1];
  assign is_pos  = !is_neg && !is_zero;

  always_comb begin
    case (cond_code[2:1])
      2'b00:   base = is_zero;
      2'b01:   base = is_neg;
      2'b10:   base = is_pos;
      default: base = 1'b0;
    endcase
    hit = base ^ cond_code[0];
  end

endmodule

// File: rtl/unop_unit.sv
module unop_unit
  import unop_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int REG_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [3:0]        in_op,
  input  logic [REG_W-1:0]  in_src_idx,
  input  logic [DATA_W-1:0] in_src_val,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result,
  output logic              out_illegal
);

  localparam logic [REG_W-1:0] ZERO_IDX = '1;

  if (!(DATA_W == 32 || DATA_W == 64)) begin : g_bad_width
    initial $fatal(1, "unop_unit: DATA_W must be 32 or 64");
  end

  logic [DATA_W-1:0]      operand;
  unop_kind_e             kind;
  logic [FIELD_SEL_W-1:0] field_sel;
  logic [2:0]             cond_code;
  logic [DATA_W-1:0]      zext_val, sext_val, swap_val;
  logic                   cond_hit;
  logic [DATA_W-1:0]      result_d;
  logic                   illegal_d;

  assign operand = (in_src_idx == ZERO_IDX) ? '0 : in_src_val;

  unop_decode u_decode (
    .op        (in_op),
    .kind      (kind),
    .field_sel (field_sel),
    .cond_code (cond_code)
  );

  unop_extend #(.DATA_W(DATA_W)) u_extend (
    .operand   (operand),
    .field_sel (field_sel),
    .zext_val  (zext_val),
    .sext_val  (sext_val),
    .swap_val  (swap_val)
  );

  unop_cond #(.DATA_W(DATA_W)) u_cond (
    .operand   (operand),
    .cond_code (cond_code),
    .hit       (cond_hit)
  );

  always_comb begin
    illegal_d = 1'b0;
    result_d  = '0;
    case (kind)
      KIND_ZEXT: result_d = zext_val;
      KIND_SEXT: result_d = sext_val;
      KIND_SWAP: result_d = swap_val;
      KIND_COND: result_d = {{(DATA_W-1){1'b0}}, cond_hit};
      default:   illegal_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_illegal <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result  <= result_d;
        out_illegal <= illegal_d;
      end
    end
  end

  // R2: strobe follows the request by exactly one cycle
  p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R9: no request, no change
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_result) && $stable(out_illegal)));

  // R8: an illegal result carries no data
  p_illegal_zero_r8: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> (out_result == '0));
  p_reserved_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_op == 4'h0 || in_op == 4'hE || in_op == 4'hF)) |=> out_illegal);

  // R6: set-on-condition results are 0 or 1
  p_cond_boolean_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op >= 4'h8 && in_op <= 4'hD) |=> (out_result[DATA_W-1:1] == '0));

  // R3: byte zero extension clears the upper part
  p_zext_byte_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 4'h1) |=> (out_result[DATA_W-1:8] == '0));

  // R4: byte sign extension replicates bit 7
  p_sext_byte_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 4'h5) |=> (out_result[DATA_W-1:8] == {(DATA_W-8){out_result[7]}}));

  // R7: index 15 is zero, so the zero test returns 1
  p_zero_src_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_src_idx == ZERO_IDX && in_op == 4'h8) |=> (out_result == DATA_W'(1)));

endmodule

// File: tb/unop_unit_tb.sv
module unop_unit_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [3:0]  in_op;
  logic [3:0]  in_src_idx;
  logic [63:0] in_src_val;

  logic        v64, il64, v32, il32;
  logic [63:0] r64;
  logic [31:0] r32;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  unop_unit #(.DATA_W(64)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_src_idx(in_src_idx), .in_src_val(in_src_val),
    .out_valid(v64), .out_result(r64), .out_illegal(il64)
  );

  unop_unit #(.DATA_W(32)) u_dut_w32 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_src_idx(in_src_idx), .in_src_val(in_src_val[31:0]),
    .out_valid(v32), .out_result(r32), .out_illegal(il32)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (op=%h idx=%0d val=%h)",
               tag, act, exp, in_op, in_src_idx, in_src_val);
    end
  endtask

  function automatic logic [63:0] model(input logic [3:0] op, input logic [3:0] idx,
                                        input logic [63:0] val, input int w,
                                        output logic bad);
    logic [63:0] msk, a, r;
    logic neg;
    msk = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    a   = (idx == 4'd15) ? 64'd0 : (val & msk);
    neg = a[w-1];
    bad = 1'b0;
    r   = 64'd0;
    case (op)
      4'h1: r = a & 64'hFF;
      4'h2: r = a & 64'hFFFF;
      4'h3: r = a & 64'hFFFF_FFFF;
      4'h4: for (int b = 0; b < w/8; b++) r[8*b +: 8] = a[8*(w/8-1-b) +: 8];
      4'h5: r = {{56{a[7]}}, a[7:0]} & msk;
      4'h6: r = {{48{a[15]}}, a[15:0]} & msk;
      4'h7: r = {{32{a[31]}}, a[31:0]} & msk;
      4'h8: r = {63'd0, a == 64'd0};
      4'h9: r = {63'd0, a != 64'd0};
      4'hA: r = {63'd0, neg};
      4'hB: r = {63'd0, !neg};
      4'hC: r = {63'd0, !neg && a != 64'd0};
      4'hD: r = {63'd0, !(!neg && a != 64'd0)};
      default: begin r = 64'd0; bad = 1'b1; end
    endcase
    return r;
  endfunction

  function automatic string tag_of(input logic [3:0] op, input logic [3:0] idx);
    if (idx == 4'd15) return "R7";
    case (op)
      4'h1, 4'h2, 4'h3: return "R3";
      4'h4:             return "R5";
      4'h5, 4'h6, 4'h7: return "R4";
      4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hD: return "R6";
      default:          return "R8";
    endcase
  endfunction

  task automatic run_one(input logic [3:0] op, input logic [3:0] idx, input logic [63:0] val);
    logic [63:0] e64, e32;
    logic b64, b32;
    string t;
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_src_idx = idx; in_src_val = val;
    e64 = model(op, idx, val, 64, b64);
    e32 = model(op, idx, val, 32, b32);
    t = tag_of(op, idx);
    @(posedge clk); #1;
    chk("R2 valid64", {63'd0, v64}, 64'd1);
    chk("R2 valid32", {63'd0, v32}, 64'd1);
    chk({t, " result64"}, r64, e64);
    chk((op == 4'h3 || op == 4'h7) && idx != 4'd15 ? "R10 result32" : {t, " result32"},
        {32'd0, r32}, e32);
    chk("R8 illegal64", {63'd0, il64}, {63'd0, b64});
    chk("R8 illegal32", {63'd0, il32}, {63'd0, b32});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] vals [16];
    logic [63:0] lfsr;
    logic [63:0] keep64;
    logic [31:0] keep32;
    rst = 1'b1; in_valid = 1'b0; in_op = 4'h0; in_src_idx = 4'd0; in_src_val = 64'd0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 valid", {63'd0, v64}, 64'd0);
    chk("R1 result", r64, 64'd0);
    chk("R1 illegal", {63'd0, il64}, 64'd0);
    chk("R1 result32", {32'd0, r32}, 64'd0);
    @(negedge clk); rst = 1'b0;

    vals[0]  = 64'h0;                  vals[1]  = 64'h1;
    vals[2]  = 64'hFFFF_FFFF_FFFF_FFFF; vals[3]  = 64'h80;
    vals[4]  = 64'h7F;                 vals[5]  = 64'h8000;
    vals[6]  = 64'h7FFF;               vals[7]  = 64'h8000_0000;
    vals[8]  = 64'h7FFF_FFFF;          vals[9]  = 64'h0123_4567_89AB_CDEF;
    vals[10] = 64'h8000_0000_0000_0000; vals[11] = 64'h7FFF_FFFF_FFFF_FFFF;
    vals[12] = 64'h1_0000_0000;        vals[13] = 64'hFEDC_BA98_7654_3210;
    vals[14] = 64'h0000_0000_FFFF_FF00; vals[15] = 64'h00FF_00FF_8001_7F80;

    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 16; i++) begin
        run_one(4'(op), 4'd3, vals[i]);
        run_one(4'(op), 4'd15, vals[i]);
      end

    lfsr = 64'hACE1_2468_1357_BDF0;
    for (int n = 0; n < 24; n++) begin
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      for (int op = 0; op < 16; op++)
        run_one(4'(op), 4'(n % 15), lfsr);
    end

    // R9: idle cycles with changing inputs leave the outputs untouched
    run_one(4'h4, 4'd2, 64'h1122_3344_5566_7788);
    keep64 = r64; keep32 = r32;
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      in_valid = 1'b0; in_op = 4'(n + 14); in_src_idx = 4'd1; in_src_val = 64'hDEAD_0000 + 64'(n);
      @(posedge clk); #1;
      chk("R2 idle valid", {63'd0, v64}, 64'd0);
      chk("R9 hold result64", r64, keep64);
      chk("R9 hold result32", {32'd0, r32}, {32'd0, keep32});
      chk("R9 hold illegal", {63'd0, il64}, 64'd0);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule